// File: doc/BRIEF.md
# Serial Port Bit-Clock and Frame-Sync Generator

This block produces the bit clock and the frame-sync pulse for a synchronous serial audio port. A programmable divider turns a source clock into a bit clock; a frame counter, stepped once per bit clock, produces a frame-sync pulse whose period and active width are both programmable. The source is either the block's own clock or an external clock input that is sampled and edge-counted, which is how the divider is fed when the bit clock comes from outside.

Configuration goes through a simple write port with three registers: a generator register (divider, width, period, sync mode, source), a control register (clock-stage run bit and frame-stage run bit) and a pin register (per-signal polarity inversion and output-enable selection). Generator settings are held in a shadow copy and move into the active copy only at a frame boundary, so a frame in flight is never cut short. A frame can either repeat on its own or be started once per data-load strobe.

Top module: `serial_clk_fs_gen`

## Requirements
- R1: With divider field D (generator register bits 7:0) the bit clock repeats every D+1 source ticks; it is low for floor(D/2)+1 ticks and high for the rest. With D=0 the bit clock level stays low.
- R2: With period field P (generator register bits 27:16, up to 4095) a frame lasts P+1 bit clocks, so frame-sync rising edges are (P+1)*(D+1) clock cycles apart with the internal source.
- R3: With width field W (generator register bits 15:8) frame sync is active for the first W+1 bit clocks of each frame; when W >= P it stays active continuously.
- R4: Generator register bit 29 set selects the block clock as the source (one tick per cycle); cleared, each rising edge of `extClk` (sampled by `clk`) is one tick.
- R5: Control register (address 1) bit 22 runs the clock stage; bit 23 additionally runs the frame stage. With bit 22 clear both outputs rest at their idle level (low before inversion); with only bit 22 set the bit clock toggles and frame sync stays inactive.
- R6: Pin register (address 2) bits 0..3 invert, in that order, the receive clock, transmit clock, receive frame sync and transmit frame sync outputs, and take effect on the next cycle.
- R7: Pin register bits 8..11 drive `pinOe[0..3]` (receive clock, transmit clock, receive frame sync, transmit frame sync).
- R8: A generator register (address 0) write made during a running frame does not change that frame; the new settings apply from the next frame.
- R9: With generator register bit 28 cleared, frame sync appears only after a `dataLoad` pulse, for exactly one frame; with bit 28 set frames repeat on their own.
- R10: After reset all clock and frame-sync outputs and `pinOe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal divider source |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 generator, 1 control, 2 pin, 3 ignored |
| wrData | input | 32 | Register write data |
| extClk | input | 1 | External divider source, edge-counted |
| dataLoad | input | 1 | Starts one frame when periodic sync is off |
| rxClkO | output | 1 | Receive bit clock |
| txClkO | output | 1 | Transmit bit clock |
| rxFsO | output | 1 | Receive frame sync |
| txFsO | output | 1 | Transmit frame sync |
| pinOe | output | 4 | Output-enable selections for the four pins |

## Verification
A divider count that escapes its range shows up as a missing bit-clock edge within one bit period, and a frame count past its period as a missing frame-sync rise within one frame; both are measured as edge-to-edge cycle counts on the pins. A shadow copy committed too early is seen in the very frame during which it was written, since that frame's length changes. A stuck one-shot arm shows up within one frame as a second, unrequested pulse.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int DIV_W = 8;
  localparam int WID_W = 8;
  localparam int PER_W = 12;
  localparam int DIV_LSB = 0;
  localparam int WID_LSB = 8;
  localparam int PER_LSB = 16;
  localparam int PERIODIC_BIT = 28;
  localparam int INTSRC_BIT = 29;
  localparam int CLKRUN_BIT = 22;
  localparam int FSRUN_BIT = 23;
  localparam logic [1:0] ADDR_GEN = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_PIN = 2'd2;

  typedef struct packed {
    logic             intSrc;
    logic             periodic;
    logic [PER_W-1:0] period;
    logic [WID_W-1:0] width;
    logic [DIV_W-1:0] div;
  } genCfg_t;

  typedef struct packed {
    logic clkRun;
    logic fsRun;
    logic fsLive;
  } strobe_t;
endpackage

// File: rtl/sfg_ctrl.sv
module sfg_ctrl
  import sfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        dataLoad,
  input  logic        bitTick,
  input  logic        frameEnd,
  output genCfg_t     actCfg,
  output strobe_t     strobes,
  output logic [3:0]  pinPol,
  output logic [3:0]  pinDir
);
  genCfg_t shadowCfg;
  logic clkRunQ, fsRunQ, armedQ, commit;
  logic unusedBits;
  assign unusedBits = ^wrData[31:30];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= '0;
      clkRunQ   <= 1'b0;
      fsRunQ    <= 1'b0;
      pinPol    <= '0;
      pinDir    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_GEN: begin
          shadowCfg.div      <= wrData[DIV_LSB +: DIV_W];
          shadowCfg.width    <= wrData[WID_LSB +: WID_W];
          shadowCfg.period   <= wrData[PER_LSB +: PER_W];
          shadowCfg.periodic <= wrData[PERIODIC_BIT];
          shadowCfg.intSrc   <= wrData[INTSRC_BIT];
        end
        ADDR_CTRL: begin
          clkRunQ <= wrData[CLKRUN_BIT];
          fsRunQ  <= wrData[FSRUN_BIT];
        end
        ADDR_PIN: begin
          pinPol <= wrData[3:0];
          pinDir <= wrData[11:8];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobes.clkRun = clkRunQ;
    strobes.fsRun  = fsRunQ;
    strobes.fsLive = actCfg.periodic | armedQ;
  end

  // settings move only when no frame is in flight or at its last bit
  assign commit = !clkRunQ || (bitTick && !(fsRunQ && strobes.fsLive)) || frameEnd;

  always_ff @(posedge clk) begin
    if (!rstN)       actCfg <= '0;
    else if (commit) actCfg <= shadowCfg;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                     armedQ <= 1'b0;
    else if (!clkRunQ || !fsRunQ || actCfg.periodic) armedQ <= 1'b0;
    else if (armedQ && frameEnd)                   armedQ <= 1'b0;
    else if (dataLoad)                             armedQ <= 1'b1;
  end

  p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(actCfg));
  p_one_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && frameEnd) |=> !strobes.fsLive || actCfg.periodic);
endmodule

// File: rtl/sfg_datapath.sv
module sfg_datapath
  import sfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  genCfg_t actCfg,
  input  strobe_t strobes,
  input  logic    extClk,
  output logic    bitTick,
  output logic    frameEnd,
  output logic    bitClk,
  output logic    fsActive
);
  logic [DIV_W-1:0] divCnt;
  logic [PER_W-1:0] fsCnt;
  logic extPrev, srcTick, frameOn;

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extClk;
  end

  assign srcTick  = actCfg.intSrc ? 1'b1 : (extClk & ~extPrev);
  assign bitTick  = strobes.clkRun && srcTick && (divCnt == actCfg.div);
  assign frameOn  = strobes.clkRun && strobes.fsRun && strobes.fsLive;
  assign frameEnd = bitTick && frameOn && (fsCnt == actCfg.period);

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.clkRun) divCnt <= '0;
    else if (srcTick) divCnt <= (divCnt == actCfg.div) ? '0 : divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !frameOn) fsCnt <= '0;
    else if (bitTick)      fsCnt <= (fsCnt == actCfg.period) ? '0 : fsCnt + 1'b1;
  end

  assign bitClk   = strobes.clkRun && (divCnt > (actCfg.div >> 1));
  assign fsActive = frameOn && (fsCnt <= {{(PER_W-WID_W){1'b0}}, actCfg.width});

  p_div_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clkRun |-> divCnt <= actCfg.div);
  p_fs_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    fsCnt <= actCfg.period);
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> fsCnt == '0);
  p_stop_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clkRun |=> (divCnt == '0 && fsCnt == '0));
endmodule

// File: rtl/serial_clk_fs_gen.sv
module serial_clk_fs_gen
  import sfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        extClk,
  input  logic        dataLoad,
  output logic        rxClkO,
  output logic        txClkO,
  output logic        rxFsO,
  output logic        txFsO,
  output logic [3:0]  pinOe
);
  genCfg_t actCfg;
  strobe_t strobes;
  logic [3:0] pinPol, pinDir;
  logic bitTick, frameEnd, bitClk, fsActive;

  sfg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dataLoad(dataLoad), .bitTick(bitTick), .frameEnd(frameEnd),
    .actCfg(actCfg), .strobes(strobes), .pinPol(pinPol), .pinDir(pinDir)
  );

  sfg_datapath dp_i (
    .clk(clk), .rstN(rstN), .actCfg(actCfg), .strobes(strobes), .extClk(extClk),
    .bitTick(bitTick), .frameEnd(frameEnd), .bitClk(bitClk), .fsActive(fsActive)
  );

  assign rxClkO = bitClk   ^ pinPol[0];
  assign txClkO = bitClk   ^ pinPol[1];
  assign rxFsO  = fsActive ^ pinPol[2];
  assign txFsO  = fsActive ^ pinPol[3];
  assign pinOe  = pinDir;

  p_idle_out_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clkRun |-> (txClkO == pinPol[1] && txFsO == pinPol[3]));
endmodule

// File: tb/serial_clk_fs_gen_tb.sv
module serial_clk_fs_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, extClk = 1'b0, dataLoad = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic rxClkO, txClkO, rxFsO, txFsO;
  logic [3:0] pinOe;
  int nChk = 0, nFail = 0;
  bit extOn = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_clk_fs_gen dut_i (.*);

  initial begin : ext_src
    int ph = 0;
    forever begin
      @(negedge clk);
      if (extOn) begin
        ph++;
        if (ph == 3) begin ph = 0; extClk = ~extClk; end
      end
    end
  end

  function automatic logic [31:0] genWord(int d, int w, int p, bit per, bit intS);
    return (32'(intS) << 29) | (32'(per) << 28) | (32'(p) << 16) | (32'(w) << 8) | 32'(d);
  endfunction

  function automatic bit sig(int s);
    case (s)
      0: return txClkO;
      1: return txFsO;
      2: return rxClkO;
      default: return rxFsO;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitRise(int s, output int n);
    bit prev = sig(s);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (sig(s) && !prev) return;
      prev = sig(s);
    end
    n = -1;
  endtask

  task automatic highLen(int s, output int n);
    n = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!sig(s)) return;
      n++;
    end
  endtask

  task automatic countHigh(int s, int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sig(s)) n++;
    end
  endtask

  task automatic start(logic [31:0] g, logic [31:0] pin);
    wr(1, 0); wr(0, g); wr(2, pin); wr(1, 32'h00C0_0000);
  endtask

  initial begin : stim
    int n, m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {rxClkO, txClkO, rxFsO, txFsO}, 0);
    chk("R10 reset pinOe", pinOe, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int it = 0; it < 6; it++) begin
      int d = $urandom % 6, w = $urandom % 4, p;
      p = w + 1 + $urandom % 6;
      start(genWord(d, w, p, 1, 1), 0);
      waitRise(1, n); waitRise(1, n);
      chk("R2 frame period", n, (p + 1) * (d + 1));
      highLen(1, n);
      chk("R3 sync width", n, (w + 1) * (d + 1));
      if (d > 0) begin
        waitRise(0, n); waitRise(0, n);
        chk("R1 bit period", n, d + 1);
        highLen(0, n);
        chk("R1 bit high time", n, d - d / 2);
      end
    end

    start(genWord(0, 0, 4095, 1, 1), 0);
    waitRise(1, n); waitRise(1, n);
    chk("R2 max period", n, 4096);
    highLen(1, n);
    chk("R3 one-bit width", n, 1);
    countHigh(0, 30, n);
    chk("R1 D=0 level low", n, 0);

    start(genWord(0, 5, 3, 1, 1), 0);
    countHigh(1, 40, n);
    chk("R3 width>=period held", n, 40);

    start(genWord(1, 0, 3, 1, 1), 0);
    waitRise(1, n); waitRise(1, n);
    wr(0, genWord(1, 0, 9, 1, 1));
    waitRise(1, n);
    chk("R8 frame in flight kept", n + 1, 8);
    waitRise(1, n);
    chk("R8 new period applied", n, 20);

    start(genWord(1, 0, 3, 1, 1), 32'h0000_0500);
    chk("R7 pinOe", pinOe, 4'b0101);
    wr(2, 32'h0000_000A);
    n = 0; m = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txClkO == rxClkO) n++;
      if (txFsO == rxFsO) m++;
    end
    chk("R6 clock inversion", n, 0);
    chk("R6 sync inversion", m, 0);
    wr(2, 0);

    wr(1, 0);
    @(negedge clk);
    countHigh(0, 30, n); countHigh(1, 30, m);
    chk("R5 stopped clock", n, 0);
    chk("R5 stopped sync", m, 0);
    wr(1, 32'h0040_0000);
    countHigh(0, 40, n); countHigh(1, 40, m);
    chk("R5 clock stage only", n, 20);
    chk("R5 no sync without bit 23", m, 0);

    start(genWord(0, 2, 4, 0, 1), 0);
    countHigh(1, 60, n);
    chk("R9 no sync before load", n, 0);
    dataLoad = 1'b1; @(negedge clk); dataLoad = 1'b0;
    countHigh(1, 80, n);
    chk("R9 single frame per load", n + (sig(1) ? 0 : 0), 2);

    extOn = 1'b1;
    start(genWord(1, 0, 3, 1, 0), 0);
    waitRise(0, n); waitRise(0, n);
    chk("R4 external source period", n, 12);
    waitRise(1, n); waitRise(1, n);
    chk("R4 external frame period", n, 48);
    extOn = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end
endmodule